// File: doc/BRIEF.md
# Serially Controlled Clock Fan-out Gate

This block distributes one reference clock to ten clock outputs. Each output has its own enable bit. An enabled output follows the reference clock. A disabled output is parked low. The enable bits sit in three write-only byte registers, and a host loads them over a two-wire SMBus-style serial link. After reset every output is enabled. A dedicated pad enable input overrides the register contents: when it is low, the drivers of all ten outputs are turned off, so the pads float.

The serial side runs on a system clock that oversamples the bus. A frame has this shape: a start condition, an address byte, a command byte, a byte count, and then data bytes. Data bytes fill registers 0, 1 and 2 in that order. The block acknowledges each byte of a frame whose address matches. It stays silent for any other address.

An enable change crosses into the reference clock domain. It is applied only on a falling edge of the reference clock. As a result, no output ever shows a pulse that is shorter than the input clock's own high phase.

Top module: `clkfan_gate_ctrl`

## Requirements
- R1: After reset all ten enable bits are 1, so every output follows the reference clock, and `sda_pull` is 0.
- R2: An address byte of 7-bit address 1101001 with direction bit 0 (byte value 0xD2) is acknowledged. Any other address byte, including 0xD3 (read direction), gets no acknowledge. Every later byte of that frame is then left unacknowledged and has no effect on any output.
- R3: Serial bits are taken most significant first. The first data byte after the count byte loads register 0, the second loads register 1 and the third loads register 2. A frame with fewer data bytes leaves the registers it does not reach unchanged.
- R4: Bits 3..0 of register 0 are the enables of outputs 3..0.
- R5: Bits 7..4 of register 1 are the enables of outputs 7..4.
- R6: Bit 7 of register 2 enables output 9 and bit 6 enables output 8.
- R7: Register 0 bits 7..4, register 1 bits 3..0 and register 2 bits 5..0 are reserved, and writing 1 to them changes no output.
- R8: An output whose enable bit is 1 is high while the reference clock is high and low while it is low. An output whose enable bit is 0 stays low.
- R9: An output changes its gating only while the reference clock is low. An output never rises while the reference clock is low and never falls while it is high.
- R10: When `out_en` is 0, all ten bits of `clk_oe` are 0 (outputs high impedance), whatever the registers hold. When `out_en` is 1, all ten bits are 1.
- R11: Data bytes after the third are acknowledged but change no register.
- R12: In a matching frame, `sda_pull` is 1 during the acknowledge bit of the address, command, count and data bytes. It is 0 at every other point in the frame. It changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial bus clock level |
| sda_in | input | 1 | Serial bus data level as seen on the wire |
| sda_pull | output | 1 | 1 pulls the serial data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be distributed |
| out_en | input | 1 | Pad enable; 0 turns off all output drivers |
| clk_out | output | 10 | Gated copies of the reference clock, bit i is output i |
| clk_oe | output | 10 | Per-output driver enable, 1 drives the pad |

## Verification
The enable map is exercised with three kinds of data pattern:
- Bytes with every reserved bit set show whether reserved positions leak into any output.
- Single-bit bytes (0x01, 0x80, 0x40) show whether the bit order is reversed and whether bytes land in the wrong register.
- Frames of one data byte and of five data bytes show whether the register pointer stops early or wraps around.

Frames addressed to 0xD4 and 0xD3 show whether the address compare and the direction bit work. The ack pattern is checked for each of these frames.

A watch on every output edge, compared with the reference clock level, catches any clipped pulse while the enables toggle back and forth.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/100ps
package clkfan_pkg;

    localparam int NUM_OUT        = 10;
    localparam int NUM_REGS       = 3;
    localparam int PREAMBLE_BYTES = 3;   // address, command, count

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BITS,
        ST_ACK,
        ST_SKIP
    } slv_state_e;

    typedef struct packed {
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic       stb;
        logic [1:0] idx;
        logic [7:0] data;
    } wr_req_t;

    // Fold one register byte into the enable vector; reserved bits are dropped.
    function automatic logic [NUM_OUT-1:0] merge_byte(
        input logic [NUM_OUT-1:0] cur,
        input logic [1:0]         idx,
        input logic [7:0]         data
    );
        logic [NUM_OUT-1:0] nxt;
        nxt = cur;
        case (idx)
            2'd0: nxt[3:0] = data[3:0];
            2'd1: nxt[7:4] = data[7:4];
            2'd2: begin
                nxt[9] = data[7];
                nxt[8] = data[6];
            end
            default: ;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/clkfan_bus_sync.sv
`timescale 1ns/100ps
module clkfan_bus_sync
    import clkfan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output logic     scl_lvl,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        scl_lvl   = scl_s;
        evt.sda   = sda_s;
        evt.start = scl_s && scl_prev && sda_prev && !sda_s;
        evt.stop  = scl_s && scl_prev && !sda_prev && sda_s;
        evt.rise  = scl_s && !scl_prev;
        evt.fall  = !scl_s && scl_prev;
    end

endmodule

// File: rtl/clkfan_wr_slave.sv
`timescale 1ns/100ps
module clkfan_wr_slave
    import clkfan_pkg::*;
#(
    parameter logic [6:0] ADDR = 7'h69
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     sda_pull,
    output wr_req_t  wr
);

    localparam int                CNT_W      = 3;
    localparam logic [CNT_W-1:0]  IDX_MAX    = '1;
    localparam logic [CNT_W-1:0]  FIRST_DATA = CNT_W'(PREAMBLE_BYTES);
    localparam logic [CNT_W-1:0]  LAST_DATA  = CNT_W'(PREAMBLE_BYTES + NUM_REGS - 1);

    slv_state_e       state;
    logic [3:0]       bit_cnt;
    logic [CNT_W-1:0] byte_idx;
    logic [7:0]       shreg;
    logic             byte_done;
    logic             addr_ok;
    logic             is_data;
    logic [CNT_W-1:0] data_ofs;

    assign byte_done = (state == ST_BITS) && evt.fall && (bit_cnt == 4'd8);
    assign addr_ok   = (shreg[7:1] == ADDR) && !shreg[0];
    assign is_data   = (byte_idx >= FIRST_DATA) && (byte_idx <= LAST_DATA);
    assign data_ofs  = byte_idx - FIRST_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
            wr       <= '0;
        end else begin
            wr.stb <= 1'b0;
            if (evt.start) begin
                state    <= ST_BITS;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_BITS: begin
                        if (evt.rise && (bit_cnt < 4'd8)) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            if ((byte_idx == '0) && !addr_ok) begin
                                state <= ST_SKIP;
                            end else begin
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                                if (is_data) begin
                                    wr.stb  <= 1'b1;
                                    wr.idx  <= data_ofs[1:0];
                                    wr.data <= shreg;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_BITS;
                            if (byte_idx != IDX_MAX) begin
                                byte_idx <= byte_idx + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/clkfan_en_bank.sv
`timescale 1ns/100ps
module clkfan_en_bank
    import clkfan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr,
    output logic [NUM_OUT-1:0] en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '1;
        end else if (wr.stb) begin
            en <= merge_byte(en, wr.idx, wr.data);
        end
    end

endmodule

// File: rtl/clkfan_gate.sv
`timescale 1ns/100ps
module clkfan_gate #(
    parameter int SYNC = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic en_req,
    output logic gate_en,
    output logic clk_out
);

    logic [SYNC-1:0] pipe;

    // Enable moves only on the falling edge, i.e. while the reference is low.
    always_ff @(negedge ref_clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[SYNC-2:0], en_req};
        end
    end

    assign gate_en = pipe[SYNC-1];
    assign clk_out = ref_clk & gate_en;

endmodule

// File: rtl/clkfan_gate_ctrl.sv
`timescale 1ns/100ps
module clkfan_gate_ctrl
    import clkfan_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int         BUS_SYNC   = 2,
    parameter int         GATE_SYNC  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               ref_clk,
    input  logic               out_en,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_oe
);

    bus_evt_t           bus_evt;
    logic               scl_lvl;
    wr_req_t            wr_req;
    logic [NUM_OUT-1:0] en_reg;
    logic [NUM_OUT-1:0] gate_en;

    clkfan_bus_sync #(.STAGES(BUS_SYNC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .scl_lvl (scl_lvl),
        .evt     (bus_evt)
    );

    clkfan_wr_slave #(.ADDR(SLAVE_ADDR)) u_slave (
        .clk      (clk),
        .rst      (rst),
        .evt      (bus_evt),
        .sda_pull (sda_pull),
        .wr       (wr_req)
    );

    clkfan_en_bank u_bank (
        .clk (clk),
        .rst (rst),
        .wr  (wr_req),
        .en  (en_reg)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        clkfan_gate #(.SYNC(GATE_SYNC)) u_gate (
            .ref_clk (ref_clk),
            .rst     (rst),
            .en_req  (en_reg[g]),
            .gate_en (gate_en[g]),
            .clk_out (clk_out[g])
        );
    end

    assign clk_oe = {NUM_OUT{out_en}};

endmodule

// File: rtl/clkfan_gate_ctrl_chk.sv
`timescale 1ns/100ps
module clkfan_gate_ctrl_chk
    import clkfan_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ref_clk,
    input logic               scl_lvl,
    input logic               sda_pull,
    input wr_req_t            wr,
    input logic [NUM_OUT-1:0] en_reg,
    input logic [NUM_OUT-1:0] gate_en,
    input logic [NUM_OUT-1:0] clk_out
);

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_reg == '1));

    // R12
    ack_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_lvl);

    // R9
    gate_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_clk && $past(ref_clk)) |-> $stable(gate_en));

    // R8
    out_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_out != '0) |-> ref_clk);

    // R11
    write_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr.stb |-> (wr.idx < 2'd3));

endmodule

bind clkfan_gate_ctrl clkfan_gate_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_clk  (ref_clk),
    .scl_lvl  (scl_lvl),
    .sda_pull (sda_pull),
    .wr       (wr_req),
    .en_reg   (en_reg),
    .gate_en  (gate_en),
    .clk_out  (clk_out)
);

// File: tb/clkfan_gate_ctrl_bench.sv
`timescale 1ns/100ps
module clkfan_gate_ctrl_bench;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       ref_clk = 1'b0;
    logic       out_en = 1'b1;
    logic       sda_pull;
    logic [9:0] clk_out;
    logic [9:0] clk_oe;
    logic       sda_bus;
    logic [9:0] model;
    logic [9:0] out_prev = '0;
    int         errors = 0;
    int         checks = 0;
    int         glitches = 0;
    bit         done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    always #10 clk = ~clk;
    initial begin
        #0.5;
        forever #27 ref_clk = ~ref_clk;
    end

    clkfan_gate_ctrl u_clkfan_gate_ctrl (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl),
        .sda_in   (sda_bus),
        .sda_pull (sda_pull),
        .ref_clk  (ref_clk),
        .out_en   (out_en),
        .clk_out  (clk_out),
        .clk_oe   (clk_oe)
    );

    // R9 edge watch: rise only with reference high, fall only with it low
    always @(clk_out) begin
        for (int i = 0; i < 10; i++) begin
            if (clk_out[i] !== out_prev[i] && !rst) begin
                if (clk_out[i] && !ref_clk) glitches++;
                if (!clk_out[i] && ref_clk) glitches++;
            end
        end
        out_prev = clk_out;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic smb_start();
        sda_m = 1'b1; half();
        scl = 1'b1;   half();
        sda_m = 1'b0; half();
        scl = 1'b0;   half();
    endtask

    task automatic smb_stop();
        sda_m = 1'b0; half();
        scl = 1'b1;   half();
        sda_m = 1'b1; half();
    endtask

    task automatic smb_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            repeat (2) @(negedge clk);
            sda_m = b[i]; half();
            scl = 1'b1;   half();
            scl = 1'b0;
        end
        repeat (2) @(negedge clk);
        sda_m = 1'b1; half();
        scl = 1'b1;
        repeat (H/2) @(negedge clk);
        acked = (sda_bus == 1'b0);
        repeat (H/2) @(negedge clk);
        scl = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] addr_b, input int n,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input logic [7:0] d3,
                              input logic [7:0] d4, output logic [7:0] ack_mask);
        logic [7:0] bytes [8];
        logic       a;
        bytes[0] = addr_b; bytes[1] = 8'h00; bytes[2] = 8'(n);
        bytes[3] = d0; bytes[4] = d1; bytes[5] = d2; bytes[6] = d3; bytes[7] = d4;
        ack_mask = '0;
        smb_start();
        for (int k = 0; k < 3 + n; k++) begin
            smb_byte(bytes[k], a);
            ack_mask[k] = a;
        end
        smb_stop();
        repeat (4) @(negedge ref_clk);
    endtask

    task automatic check_outputs(input string tag);
        @(posedge ref_clk); #5;
        check({tag, " high phase"}, 32'(clk_out), 32'(model));
        @(negedge ref_clk); #5;
        check({tag, " low phase"}, 32'(clk_out), 32'h0);
    endtask

    task automatic t_reset();
        model = 10'h3FF;
        check("R1 sda_pull idle", 32'(sda_pull), 32'h0);
        check("R10 drivers on", 32'(clk_oe), 32'h3FF);
        check_outputs("R1 R8 all enabled after reset");
    endtask

    task automatic t_reserved_map();
        logic [7:0] m;
        send_frame(8'hD2, 3, 8'hF5, 8'h5F, 8'hBF, 8'h00, 8'h00, m);
        check("R2 R12 ack pattern matched frame", 32'(m), 32'h3F);
        model = 10'b10_0101_0101;
        check_outputs("R4 R5 R6 R7 map with reserved ones");
    endtask

    task automatic t_bit_order();
        logic [7:0] m;
        send_frame(8'hD2, 3, 8'h01, 8'h80, 8'h40, 8'h00, 8'h00, m);
        check("R12 ack pattern", 32'(m), 32'h3F);
        model = 10'b01_1000_0001;
        check_outputs("R3 R8 msb first single bits");
    endtask

    task automatic t_bad_addr();
        logic [7:0] m;
        send_frame(8'hD4, 3, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, m);
        check("R2 wrong address no ack", 32'(m), 32'h0);
        check_outputs("R2 wrong address no effect");
        send_frame(8'hD3, 3, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, m);
        check("R2 read direction no ack", 32'(m), 32'h0);
        check_outputs("R2 read direction no effect");
    endtask

    task automatic t_extra_bytes();
        logic [7:0] m;
        send_frame(8'hD2, 5, 8'h0F, 8'hF0, 8'hC0, 8'h00, 8'h00, m);
        check("R11 extra bytes acked", 32'(m), 32'hFF);
        model = 10'h3FF;
        check_outputs("R11 extra bytes discarded");
    endtask

    task automatic t_partial();
        logic [7:0] m;
        send_frame(8'hD2, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, m);
        check("R12 short frame ack", 32'(m), 32'h0F);
        model = 10'b11_1111_0000;
        check_outputs("R3 single data byte loads register 0 only");
    endtask

    task automatic t_oe();
        @(negedge clk); out_en = 1'b0; #1;
        check("R10 drivers off", 32'(clk_oe), 32'h0);
        @(negedge clk); out_en = 1'b1; #1;
        check("R10 drivers back on", 32'(clk_oe), 32'h3FF);
        check_outputs("R10 registers kept across override");
    endtask

    task automatic t_toggle();
        logic [7:0] m;
        for (int r = 0; r < 3; r++) begin
            send_frame(8'hD2, 3, 8'h0A, 8'hA0, 8'h80, 8'h00, 8'h00, m);
            send_frame(8'hD2, 3, 8'h05, 8'h50, 8'h40, 8'h00, 8'h00, m);
        end
        model = 10'b01_0101_0101;
        check_outputs("R8 after toggling");
        check("R9 no clipped pulse", 32'(glitches), 32'h0);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge ref_clk);
        t_reset();
        t_reserved_map();
        t_bit_order();
        t_bad_addr();
        t_extra_bytes();
        t_partial();
        t_oe();
        t_toggle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule